// File: doc/BRIEF.md
# Game Button Scancode Generator

This block watches a vector of nine game-button levels, already debounced, and reports each change as a keyboard-style scancode. Pressing a button produces its make sequence and releasing it produces its break sequence. Buttons on one side of the pad use a two-byte sequence that starts with an extended prefix byte. The other buttons use a single byte. The bytes leave on an 8-bit stream with a valid/ready handshake. Each new sequence also pulses the game-button bit of an event-source byte for the system event logic.

The block samples the buttons into a 16-bit status word that software-facing logic can read at any time. It does not queue changes. It remembers the last state it reported for each button and compares that with the sampled state. Any change that arrives while the stream is back-pressured therefore stays pending until the stream accepts bytes again. If several buttons differ at once, they are reported one after another, starting from the lowest status bit.

Top module: `gk_scancode_gen`

## Requirements
- R1: Status bits 1 to 9 show button inputs 0 to 8 one clock after they are sampled, where 1 means pressed.
- R2: Status bit 0 and status bits 10 to 15 always read as zero.
- R3: A press of the button in status bit 3, 4, 5, 6 or 7 emits the single byte 0x65, 0x66, 0x67, 0x68 or 0x69.
- R4: A press of the button in status bit 1, 2, 8 or 9 emits 0xE0 followed by 0x67, 0x68, 0x65 or 0x66.
- R5: A release emits the same sequence as the press, with bit 7 of the code byte set (for example 0x65 becomes 0xE5). A 0xE0 prefix is sent unchanged.
- R6: The event-source output reads 0x01 for exactly one cycle when a sequence starts, in the cycle its first byte first becomes valid. At all other times it reads 0x00.
- R7: When several buttons differ from their last reported state, their sequences are emitted in ascending status-bit order.
- R8: An 0xE0 prefix that is accepted is always followed directly by the code byte of the same button. No byte of another sequence comes between them.
- R9: While out_valid is high and out_ready is low, out_valid and out_data hold their values.
- R10: Button changes made while the stream is stalled are not lost. Each button is later reported in its final state if that differs from the state last reported for it. A press followed by a release of a button that has not been reported produces no bytes.
- R11: During and after reset, out_valid is low, the event source is 0x00 and the status word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_in | input | 9 | Debounced button levels, 1 = pressed |
| key_status | output | 16 | Sampled button status word |
| out_data | output | 8 | Scancode byte |
| out_valid | output | 1 | out_data holds a byte to transfer |
| out_ready | input | 1 | The sink accepts the byte this cycle |
| evt_src | output | 8 | Event-source byte, 0x01 pulses for a button event |

## Verification
The bench builds the block with its default parameters: nine buttons placed from status bit 1 in a 16-bit word. This reaches every entry of the code table, including both the extended and the single-byte groups, and both status bits that must stay zero. Three out_ready patterns are used: always ready, held low, and alternating every cycle. With these patterns a sequence can be stalled partway through, the scan can coalesce a press and release that cancel, and the bench can release a button whose make sequence is still waiting to be sent.

// File: rtl/gk_pkg.sv
package gk_pkg;

    localparam int KEY_CNT    = 9;
    localparam int STAT_W     = 16;
    localparam int KEY_LSB    = 1;
    localparam int BYTE_W     = 8;
    localparam int CODE_IDX_W = 4;
    localparam int BRK_BIT    = 7;
    localparam logic [BYTE_W-1:0] EXT_PREFIX = 8'hE0;
    localparam logic [BYTE_W-1:0] EVT_GAME   = 8'h01;

    typedef struct packed {
        logic              ext;
        logic [BYTE_W-1:0] code;
    } key_code_t;

    typedef enum logic [1:0] {
        EM_IDLE = 2'd0,
        EM_PFX  = 2'd1,
        EM_CODE = 2'd2
    } em_state_t;

    // idx counts from 0 for the button in status bit KEY_LSB
    function automatic key_code_t code_of(input logic [CODE_IDX_W-1:0] idx);
        key_code_t c;
        c.ext  = 1'b0;
        c.code = '0;
        case (idx)
            4'd0: begin c.ext = 1'b1; c.code = 8'h67; end
            4'd1: begin c.ext = 1'b1; c.code = 8'h68; end
            4'd2, 4'd3, 4'd4, 4'd5, 4'd6:
                  begin c.ext = 1'b0; c.code = 8'h63 + 8'(idx); end
            4'd7: begin c.ext = 1'b1; c.code = 8'h65; end
            4'd8: begin c.ext = 1'b1; c.code = 8'h66; end
            default: begin c.ext = 1'b0; c.code = '0; end
        endcase
        return c;
    endfunction

    function automatic logic [BYTE_W-1:0] break_of(input logic [BYTE_W-1:0] mk);
        logic [BYTE_W-1:0] b;
        b = mk;
        b[BRK_BIT] = 1'b1;
        return b;
    endfunction

endpackage

// File: rtl/gk_sampler.sv
module gk_sampler
    import gk_pkg::*;
#(
    parameter int N_KEYS = KEY_CNT,
    parameter int SW     = STAT_W,
    parameter int LSB    = KEY_LSB
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_KEYS-1:0] key_in,
    output logic [N_KEYS-1:0] cur,
    output logic [SW-1:0]     status
);
    always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= key_in;
    end

    for (genvar g = 0; g < SW; g++) begin : g_stat
        if (g >= LSB && g < LSB + N_KEYS) begin : g_key
            assign status[g] = cur[g-LSB];
        end else begin : g_zero
            assign status[g] = 1'b0;
        end
    end
endmodule

// File: rtl/gk_scan.sv
module gk_scan
    import gk_pkg::*;
#(
    parameter int N_KEYS = KEY_CNT,
    localparam int IW    = $clog2(N_KEYS)
) (
    input  logic [N_KEYS-1:0] cur,
    input  logic [N_KEYS-1:0] rep,
    output logic              any,
    output logic [IW-1:0]     idx
);
    logic [N_KEYS-1:0] diff;
    assign diff = cur ^ rep;

    // lowest differing bit wins
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N_KEYS - 1; i >= 0; i--) begin
            if (diff[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/gk_emit.sv
module gk_emit
    import gk_pkg::*;
#(
    parameter int N_KEYS = KEY_CNT,
    localparam int IW    = $clog2(N_KEYS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_KEYS-1:0] cur,
    input  logic              any,
    input  logic [IW-1:0]     idx,
    input  logic              out_ready,
    output logic [N_KEYS-1:0] rep,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_valid,
    output logic              evt
);
    em_state_t state;
    key_code_t sel;
    logic      brk;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= EM_IDLE;
            rep   <= '0;
            sel   <= '0;
            brk   <= 1'b0;
            evt   <= 1'b0;
        end else begin
            evt <= 1'b0;
            case (state)
                EM_IDLE: begin
                    if (any) begin
                        rep[idx] <= cur[idx];
                        sel      <= code_of(CODE_IDX_W'(idx));
                        brk      <= ~cur[idx];
                        evt      <= 1'b1;
                        state    <= code_of(CODE_IDX_W'(idx)).ext ? EM_PFX : EM_CODE;
                    end
                end
                EM_PFX:  if (out_ready) state <= EM_CODE;
                EM_CODE: if (out_ready) state <= EM_IDLE;
                default: state <= EM_IDLE;
            endcase
        end
    end

    always_comb begin
        out_valid = (state != EM_IDLE);
        case (state)
            EM_PFX:  out_data = EXT_PREFIX;
            EM_CODE: out_data = brk ? break_of(sel.code) : sel.code;
            default: out_data = '0;
        endcase
    end
endmodule

// File: rtl/gk_scancode_gen.sv
module gk_scancode_gen
    import gk_pkg::*;
#(
    parameter int N_KEYS = KEY_CNT,
    parameter int SW     = STAT_W,
    parameter int LSB    = KEY_LSB,
    localparam int IW    = $clog2(N_KEYS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_KEYS-1:0] key_in,
    output logic [SW-1:0]     key_status,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BYTE_W-1:0] evt_src
);
    logic [N_KEYS-1:0] cur;
    logic [N_KEYS-1:0] rep;
    logic              any;
    logic [IW-1:0]     idx;
    logic              evt;

    gk_sampler #(.N_KEYS(N_KEYS), .SW(SW), .LSB(LSB)) u_samp (
        .clk(clk), .rst(rst), .key_in(key_in), .cur(cur), .status(key_status)
    );

    gk_scan #(.N_KEYS(N_KEYS)) u_scan (
        .cur(cur), .rep(rep), .any(any), .idx(idx)
    );

    gk_emit #(.N_KEYS(N_KEYS)) u_emit (
        .clk(clk), .rst(rst), .cur(cur), .any(any), .idx(idx),
        .out_ready(out_ready), .rep(rep), .out_data(out_data),
        .out_valid(out_valid), .evt(evt)
    );

    assign evt_src = evt ? EVT_GAME : '0;
endmodule

// File: rtl/gk_scancode_sva.sv
module gk_scancode_sva
    import gk_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [KEY_CNT-1:0] key_in,
    input logic [STAT_W-1:0] key_status,
    input logic [BYTE_W-1:0] out_data,
    input logic              out_valid,
    input logic              out_ready,
    input logic [BYTE_W-1:0] evt_src
);
    AST_STATUS_TRACK: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> key_status[KEY_LSB+KEY_CNT-1:KEY_LSB] == $past(key_in)); // R1

    AST_STATUS_PAD: assert property (@(posedge clk) disable iff (rst)
        key_status[KEY_LSB-1:0] == '0 && key_status[STAT_W-1:KEY_LSB+KEY_CNT] == '0); // R2

    AST_CODE_RANGE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_data != EXT_PREFIX) |->
        (out_data[6:0] >= 7'h65 && out_data[6:0] <= 7'h69)); // R3

    AST_EVT_START: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> evt_src == EVT_GAME); // R6

    AST_EVT_VALID: assert property (@(posedge clk) disable iff (rst)
        evt_src != '0 |-> (out_valid && evt_src == EVT_GAME)); // R6

    AST_PFX_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_data == EXT_PREFIX) |=>
        (out_valid && out_data != EXT_PREFIX)); // R8

    AST_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R9
endmodule

bind gk_scancode_gen gk_scancode_sva u_sva (
    .clk(clk), .rst(rst), .key_in(key_in), .key_status(key_status),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .evt_src(evt_src)
);

// File: tb/tb_gk_scancode_gen.sv
module tb_gk_scancode_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [8:0]  key_in = '0;
    logic [15:0] key_status;
    logic [7:0]  out_data;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [7:0]  evt_src;

    int n_chk = 0;
    int n_fail = 0;
    int rdy_mode = 0;   // 0 ready, 1 stalled, 2 alternating
    int exp_evt = 0;
    int seen_evt = 0;
    bit finished = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;

    gk_scancode_gen dut (
        .clk(clk), .rst(rst), .key_in(key_in), .key_status(key_status),
        .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
        .evt_src(evt_src)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // bit 8 = extended, [7:0] = make code
    function automatic logic [8:0] tb_code(input int b);
        case (b)
            1: return {1'b1, 8'h67};
            2: return {1'b1, 8'h68};
            3: return {1'b0, 8'h65};
            4: return {1'b0, 8'h66};
            5: return {1'b0, 8'h67};
            6: return {1'b0, 8'h68};
            7: return {1'b0, 8'h69};
            8: return {1'b1, 8'h65};
            9: return {1'b1, 8'h66};
            default: return '0;
        endcase
    endfunction

    task automatic push_seq(input int b, input bit press, input string tag);
        logic [8:0] c;
        c = tb_code(b);
        if (c[8]) begin exp_q.push_back(8'hE0); tag_q.push_back(tag); end
        exp_q.push_back(press ? c[7:0] : (c[7:0] | 8'h80));
        tag_q.push_back(tag);
        exp_evt++;
    endtask

    // monitor: set ready for the coming edge, then score the handshake
    always @(negedge clk) begin
        if (!rst && !finished) begin
            case (rdy_mode)
                0: out_ready = 1'b1;
                1: out_ready = 1'b0;
                default: out_ready = ~out_ready;
            endcase
            if (evt_src == 8'h01) seen_evt++;
            else if (evt_src != 8'h00) check("R6 evt value", evt_src, 8'h00);
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check("R10 unexpected byte", out_data, 32'hFFFF);
                end else begin
                    string t;
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(t, out_data, e);
                end
            end
        end
    end

    task automatic drain(input string tag);
        int quiet = 0;
        for (int i = 0; i < 400 && quiet < 4; i++) begin
            @(negedge clk);
            if (exp_q.size() == 0 && !out_valid) quiet++;
            else quiet = 0;
        end
        check({tag, " queue empty"}, exp_q.size(), 0);
        check("R6 event count", seen_evt, exp_evt);
    endtask

    task automatic set_keys(input logic [8:0] v);
        @(negedge clk);
        key_in = v;
    endtask

    task automatic check_status(input string tag);
        @(negedge clk);
        @(negedge clk);
        check(tag, key_status, {6'b0, key_in, 1'b0});
        check("R2 pad bits", {key_status[15:10], key_status[0]}, 0);
    endtask

    initial begin : watchdog
        for (int i = 0; i < 100000; i++) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : stim
        key_in = 9'h1FF;
        repeat (3) @(negedge clk);
        check("R11 valid in reset", out_valid, 0);
        check("R11 status in reset", key_status, 0);
        check("R11 evt in reset", evt_src, 0);
        key_in = '0;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R11 valid after reset", out_valid, 0);
        check("R11 status after reset", key_status, 0);

        // single presses and releases, every button
        for (int b = 1; b <= 9; b++) begin
            push_seq(b, 1'b1, (tb_code(b) & 9'h100) != 0 ? "R4 make" : "R3 make");
            set_keys(key_in | (9'd1 << (b - 1)));
            check_status("R1 status press");
            drain("R3/R4");
        end
        for (int b = 1; b <= 9; b++) begin
            push_seq(b, 1'b0, "R5 break");
            set_keys(key_in & ~(9'd1 << (b - 1)));
            check_status("R1 status release");
            drain("R5");
        end

        // simultaneous presses: order by bit
        push_seq(1, 1'b1, "R7 order");
        push_seq(3, 1'b1, "R7 order");
        push_seq(9, 1'b1, "R7 order");
        set_keys(9'b1_0000_0101);
        drain("R7");
        push_seq(1, 1'b0, "R7 order");
        push_seq(3, 1'b0, "R7 order");
        push_seq(9, 1'b0, "R7 order");
        set_keys('0);
        drain("R7");

        // back-pressure
        rdy_mode = 1;
        push_seq(5, 1'b1, "R10 stalled");
        set_keys(9'b0_0001_0000);
        repeat (4) @(negedge clk);
        check("R9 valid held", out_valid, 1);
        check("R9 data held", out_data, 8'h67);
        set_keys(9'b0_1001_0010);   // press bit2, bit8, keep bit5
        set_keys(9'b0_1011_0010);   // press bit6
        set_keys(9'b0_1001_0010);   // release bit6
        set_keys(9'b0_1000_0010);   // release bit5
        repeat (3) @(negedge clk);
        check("R9 data still held", out_data, 8'h67);
        push_seq(2, 1'b1, "R10 pending");
        push_seq(5, 1'b0, "R10 pending");
        push_seq(8, 1'b1, "R10 pending");
        rdy_mode = 0;
        drain("R10");

        // alternating ready across extended sequences
        rdy_mode = 2;
        push_seq(1, 1'b1, "R8 alternating");
        push_seq(2, 1'b0, "R8 alternating");
        push_seq(8, 1'b0, "R8 alternating");
        push_seq(9, 1'b1, "R8 alternating");
        set_keys(9'b1_0000_0001);
        drain("R8");
        rdy_mode = 0;
        push_seq(1, 1'b0, "R5 break");
        push_seq(9, 1'b0, "R5 break");
        set_keys('0);
        drain("R5");
        check_status("R1 final status");

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule